// File: doc/BRIEF.md
# 4x4 Integer Forward Transform Engine

The engine turns a 4x4 block of signed 16-bit residual samples into 16 signed 16-bit transform coefficients using an integer, DCT-like transform. It is built from add/subtract butterflies and two fixed-point rotation constants, 2217 and 5352. Rows of four samples arrive one per accepted input beat. Each row goes through a horizontal pass at once, and the saturated result is written into a 4x4 transpose store.

Once all four rows are stored, a vertical pass runs on every column. The coefficients then leave one output row per beat, four lanes per beat, over four beats. A done flag marks the last beat of each block.

Both sides use a valid/ready handshake. The input side stays closed while a block is draining, so each block is processed in full before the next one is taken in. Addressing, pitch and quantization are outside this block.

Top module: `fdct4_engine`

## Requirements
- R1: Row pass, for the samples x0..x3 of one input beat, where lane j sits at bits 16j+15:16j. The pass forms a=(x0+x3)*8, b=(x1+x2)*8, c=(x1-x2)*8 and d=(x0-x3)*8. Its outputs are y0=a+b and y2=a-b.
- R2: Row pass odd outputs are y1=(c*2217+d*5352+14500)>>12 and y3=(d*2217-c*5352+7500)>>12. The shift is arithmetic and is applied to the exact wide value.
- R3: Column pass, for column values t0..t3 taken from stored rows 0..3. It forms a=t0+t3, b=t1+t2, c=t1-t2 and d=t0-t3, with no pre-scaling. Its outputs are row0=(a+b+7)>>4 and row2=(a-b+7)>>4.
- R4: Column pass odd outputs are row1=(c*2217+d*5352+12000)>>16 and row3=(d*2217-c*5352+51000)>>16.
- R5: The row1 output of a column is raised by 1 whenever that column's d term is nonzero. It is left unchanged when d is zero.
- R6: Every row-pass and column-pass result is clamped to [-32768, 32767] before it is stored or sent out. No intermediate sum or product wraps.
- R7: Input beats carry rows 0..3 in order. Output beat k (k=0..3) carries coefficient row k, with column j in bits 16j+15:16j, so each coefficient has raster index 4k+j.
- R8: in_ready is low from the cycle after the fourth row of a block is accepted until the last output beat is taken. No row is accepted while out_valid is high.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_row does not change.
- R10: out_done is high exactly while the fourth output beat of a block is offered, and never without out_valid.
- R11: After a synchronous active-low reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input row is present |
| in_ready | output | 1 | Engine can take a row |
| in_row | input | 64 | Four signed 16-bit samples, lane j at bits 16j+15:16j |
| out_valid | output | 1 | Output row is present |
| out_ready | input | 1 | Consumer takes the output row |
| out_row | output | 64 | Four signed 16-bit coefficients of one output row |
| out_done | output | 1 | High on the last output beat of a block |

## Verification
Two situations are hard to reach from random samples. The first is a column whose d term is exactly zero, which decides whether the +1 correction is skipped. The bench reaches it by sending blocks whose fourth row repeats the first, so every column has t0 equal to t3. The second is clamping in the row pass, which only happens with sums near full scale. The bench reaches it with blocks built from +32767 and -32768 in patterns that drive a+b and a-b past the 16-bit range. Random consumer stalls hold output beats, so the hold and handshake rules are exercised at every beat position.

// File: rtl/fdct4_pkg.sv
// Package fdct4_pkg
// Shared widths, transform constants and the clamp helper of the 4x4
// forward transform engine. Assumes two's complement signed arithmetic.
package fdct4_pkg;
    localparam int SAMPLE_W = 16;   // sample and coefficient width
    localparam int ACC_W    = 40;   // internal precision, no wrap possible
    localparam int DIM      = 4;    // block edge length

    localparam int ROT_LO   = 2217;
    localparam int ROT_HI   = 5352;

    // Clamp a wide signed value to the signed SAMPLE_W range.
    function automatic logic signed [SAMPLE_W-1:0] clip(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] hi;
        logic signed [ACC_W-1:0] lo;
        hi = ACC_W'((64'sd1 <<< (SAMPLE_W-1)) - 1);
        lo = -(ACC_W'(64'sd1 <<< (SAMPLE_W-1)));
        if (v > hi)      clip = hi[SAMPLE_W-1:0];
        else if (v < lo) clip = lo[SAMPLE_W-1:0];
        else             clip = v[SAMPLE_W-1:0];
    endfunction
endpackage

// File: rtl/fdct4_row.sv
// Module fdct4_row
// Horizontal pass of the transform: one row of DIM samples in, DIM clamped
// outputs out, purely combinational. Assumes AW is wide enough for the
// scaled products (ACC_W in the package).
module fdct4_row
    import fdct4_pkg::*;
#(
    parameter int DW = SAMPLE_W,
    parameter int AW = ACC_W,
    parameter int PRE_SHIFT = 3,
    parameter int ODD_SHIFT = 12,
    parameter int RND_ODD1 = 14500,
    parameter int RND_ODD3 = 7500
) (
    input  logic [4*DW-1:0] row_in,
    output logic [4*DW-1:0] row_out
);
    localparam logic signed [AW-1:0] K_LO = AW'(ROT_LO);
    localparam logic signed [AW-1:0] K_HI = AW'(ROT_HI);
    localparam logic signed [AW-1:0] R1C  = AW'(RND_ODD1);
    localparam logic signed [AW-1:0] R3C  = AW'(RND_ODD3);

    logic signed [AW-1:0] x0, x1, x2, x3;
    logic signed [AW-1:0] a, b, c, d;
    logic signed [AW-1:0] y0, y1, y2, y3;

    // Sign-extend the four lanes.
    always_comb begin
        x0 = AW'(signed'(row_in[0*DW +: DW]));
        x1 = AW'(signed'(row_in[1*DW +: DW]));
        x2 = AW'(signed'(row_in[2*DW +: DW]));
        x3 = AW'(signed'(row_in[3*DW +: DW]));
    end

    // Butterfly with pre-scaling, then the even and rotated odd outputs.
    always_comb begin
        a  = (x0 + x3) <<< PRE_SHIFT;
        b  = (x1 + x2) <<< PRE_SHIFT;
        c  = (x1 - x2) <<< PRE_SHIFT;
        d  = (x0 - x3) <<< PRE_SHIFT;
        y0 = a + b;
        y2 = a - b;
        y1 = (c * K_LO + d * K_HI + R1C) >>> ODD_SHIFT;
        y3 = (d * K_LO - c * K_HI + R3C) >>> ODD_SHIFT;
    end

    // Clamp every result to the sample range.
    always_comb begin
        row_out[0*DW +: DW] = clip(y0);
        row_out[1*DW +: DW] = clip(y1);
        row_out[2*DW +: DW] = clip(y2);
        row_out[3*DW +: DW] = clip(y3);
    end
endmodule

// File: rtl/fdct4_col.sv
// Module fdct4_col
// Vertical pass for one column: lane i of col_in is the value from stored
// row i, lane i of col_out is coefficient row i. Combinational. Applies the
// +1 correction to output row 1 when the column difference is nonzero.
module fdct4_col
    import fdct4_pkg::*;
#(
    parameter int DW = SAMPLE_W,
    parameter int AW = ACC_W,
    parameter int EVEN_SHIFT = 4,
    parameter int ODD_SHIFT = 16,
    parameter int RND_EVEN = 7,
    parameter int RND_ODD1 = 12000,
    parameter int RND_ODD3 = 51000
) (
    input  logic [4*DW-1:0] col_in,
    output logic [4*DW-1:0] col_out
);
    localparam logic signed [AW-1:0] K_LO = AW'(ROT_LO);
    localparam logic signed [AW-1:0] K_HI = AW'(ROT_HI);
    localparam logic signed [AW-1:0] REC  = AW'(RND_EVEN);
    localparam logic signed [AW-1:0] R1C  = AW'(RND_ODD1);
    localparam logic signed [AW-1:0] R3C  = AW'(RND_ODD3);

    logic signed [AW-1:0] t0, t1, t2, t3;
    logic signed [AW-1:0] a, b, c, d;
    logic signed [AW-1:0] z0, z1, z2, z3;

    // Sign-extend the column values.
    always_comb begin
        t0 = AW'(signed'(col_in[0*DW +: DW]));
        t1 = AW'(signed'(col_in[1*DW +: DW]));
        t2 = AW'(signed'(col_in[2*DW +: DW]));
        t3 = AW'(signed'(col_in[3*DW +: DW]));
    end

    // Butterfly, rounding shifts and the difference-driven correction.
    always_comb begin
        a  = t0 + t3;
        b  = t1 + t2;
        c  = t1 - t2;
        d  = t0 - t3;
        z0 = (a + b + REC) >>> EVEN_SHIFT;
        z2 = (a - b + REC) >>> EVEN_SHIFT;
        z1 = (c * K_LO + d * K_HI + R1C) >>> ODD_SHIFT;
        if (d != '0) z1 = z1 + AW'(1);
        z3 = (d * K_LO - c * K_HI + R3C) >>> ODD_SHIFT;
    end

    // Clamp every result to the sample range.
    always_comb begin
        col_out[0*DW +: DW] = clip(z0);
        col_out[1*DW +: DW] = clip(z1);
        col_out[2*DW +: DW] = clip(z2);
        col_out[3*DW +: DW] = clip(z3);
    end
endmodule

// File: rtl/fdct4_engine.sv
// Module fdct4_engine
// Top of the 4x4 forward transform. Accepts DIM rows through a valid/ready
// input, runs the row pass on each and stores it in a transpose store, then
// offers DIM output rows produced by the column pass. Assumes the consumer
// follows valid/ready; the input stays closed while a block drains.
module fdct4_engine
    import fdct4_pkg::*;
#(
    parameter int DW = SAMPLE_W,
    parameter int N  = DIM
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [N*DW-1:0] in_row,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [N*DW-1:0] out_row,
    output logic            out_done
);
    localparam int CW = $clog2(N);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [N*DW-1:0] row_y;
    logic [N*DW-1:0] tbuf   [N];
    logic [N*DW-1:0] col_in [N];
    logic [N*DW-1:0] col_out[N];
    logic [N*DW-1:0] grid   [N];
    logic [CW-1:0]   fill_cnt;
    logic [CW-1:0]   drain_cnt;
    logic            draining;
    logic            accept;
    logic            take;

    fdct4_row #(.DW(DW)) u_row (.row_in(in_row), .row_out(row_y));

    // One column pass per column; rebuild raster rows from the results.
    for (genvar j = 0; j < N; j++) begin : g_col
        for (genvar i = 0; i < N; i++) begin : g_lane
            assign col_in[j][i*DW +: DW] = tbuf[i][j*DW +: DW];
            assign grid[i][j*DW +: DW]   = col_out[j][i*DW +: DW];
        end
        fdct4_col #(.DW(DW)) u_col (.col_in(col_in[j]), .col_out(col_out[j]));
    end

    assign in_ready  = !draining;
    assign accept    = in_valid && in_ready;
    assign out_valid = draining;
    assign take      = draining && out_ready;
    assign out_row   = grid[drain_cnt];
    assign out_done  = draining && (drain_cnt == LAST);

    // Write row-pass results into the transpose store.
    always_ff @(posedge clk) begin
        if (accept) tbuf[fill_cnt] <= row_y;
    end

    // Sequence filling and draining of one block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt  <= '0;
            drain_cnt <= '0;
            draining  <= 1'b0;
        end else begin
            if (accept) begin
                fill_cnt <= fill_cnt + 1'b1;
                if (fill_cnt == LAST) draining <= 1'b1;
            end
            if (take) begin
                drain_cnt <= drain_cnt + 1'b1;
                if (drain_cnt == LAST) draining <= 1'b0;
            end
        end
    end

    // R8: no row enters while output is pending.
    a_r8_closed_while_draining: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R9: a stalled beat holds.
    a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row)));

    // R10: done only accompanies a valid beat.
    a_r10_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> out_valid);

    // R7: beats of one block follow without a gap once started.
    a_r7_beats_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_done) |=> out_valid);

    // R8: after the last beat is taken the input reopens.
    a_r8_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_ready) |=> in_ready);
endmodule

// File: tb/sim_fdct4_engine.sv
module sim_fdct4_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_row = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_row;
    logic        out_done;

    int          n_chk = 0;
    int          n_bad = 0;
    int          exp_q[$];
    int          blk[16];
    int          beat = 0;
    bit          stall_mode = 1'b0;
    bit          prev_stall = 1'b0;
    logic [63:0] prev_row;
    bit          finished = 1'b0;
    int          cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    fdct4_engine u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
                     .in_row(in_row), .out_valid(out_valid), .out_ready(out_ready),
                     .out_row(out_row), .out_done(out_done));

    function automatic int sat(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // Reference: both passes from the requirement formulas.
    function automatic void ref_block(input int x[16], output int y[16]);
        int     t[16];
        longint a, b, c, d, z;
        for (int r = 0; r < 4; r++) begin
            a = 8 * longint'(x[4*r] + x[4*r+3]);
            b = 8 * longint'(x[4*r+1] + x[4*r+2]);
            c = 8 * longint'(x[4*r+1] - x[4*r+2]);
            d = 8 * longint'(x[4*r] - x[4*r+3]);
            t[4*r]   = sat(a + b);
            t[4*r+2] = sat(a - b);
            t[4*r+1] = sat((c * 2217 + d * 5352 + 14500) >>> 12);
            t[4*r+3] = sat((d * 2217 - c * 5352 + 7500) >>> 12);
        end
        for (int j = 0; j < 4; j++) begin
            a = t[j] + t[12+j];
            b = t[4+j] + t[8+j];
            c = t[4+j] - t[8+j];
            d = t[j] - t[12+j];
            y[j]    = sat((a + b + 7) >>> 4);
            y[8+j]  = sat((a - b + 7) >>> 4);
            z = (c * 2217 + d * 5352 + 12000) >>> 16;
            if (d != 0) z = z + 1;
            y[4+j]  = sat(z);
            y[12+j] = sat((d * 2217 - c * 5352 + 51000) >>> 16);
        end
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Queue the expected coefficients, then drive the four rows.
    task automatic send_block(int gap);
        int y[16];
        ref_block(blk, y);
        for (int i = 0; i < 16; i++) exp_q.push_back(y[i]);
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            in_valid = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
            in_valid = 1'b1;
            for (int j = 0; j < 4; j++) in_row[16*j +: 16] = 16'(blk[4*r+j]);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic int pick();
        int s = int'($urandom % 8);
        if (s == 0) return 32767;
        if (s == 1) return -32768;
        return int'($signed(16'($urandom)));
    endfunction

    // Consumer back-pressure.
    always @(negedge clk) out_ready <= stall_mode ? (($urandom % 3) != 0) : 1'b1;

    // Monitor: sample 5 ns before each rising edge.
    always @(negedge clk) begin
        #5;
        if (rst_n && !finished) begin
            check(in_ready == !out_valid, "R8 in_ready vs out_valid", int'(in_ready), int'(!out_valid));
            if (prev_stall) begin
                check(out_valid == 1'b1, "R9 valid held", int'(out_valid), 1);
                check(out_row == prev_row, "R9 row held", int'(out_row[15:0]), int'(prev_row[15:0]));
            end
            prev_stall = out_valid && !out_ready;
            prev_row   = out_row;
            if (out_valid) begin
                check(out_done == (beat == 3), "R10 done on last beat", int'(out_done), int'(beat == 3));
                check(exp_q.size() >= 4, "R7 beat expected", exp_q.size(), 4);
            end
            if (out_valid && out_ready && exp_q.size() >= 4) begin
                for (int j = 0; j < 4; j++) begin
                    int e;
                    int a;
                    e = exp_q.pop_front();
                    a = int'($signed(out_row[16*j +: 16]));
                    case (beat)
                        0, 2:    check(a == e, "R3 even row (R1 R6 R7)", a, e);
                        1:       check(a == e, "R4 R5 row1 (R2 R6 R7)", a, e);
                        default: check(a == e, "R4 row3 (R2 R6 R7)", a, e);
                    endcase
                end
                beat = (beat + 1) % 4;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        check(in_ready == 1'b1, "R11 reset in_ready", int'(in_ready), 1);
        check(out_valid == 1'b0, "R11 reset out_valid", int'(out_valid), 0);
        // all zero
        for (int i = 0; i < 16; i++) blk[i] = 0;
        send_block(0);
        // full-scale positive and negative: R6 clamp in the row pass
        for (int i = 0; i < 16; i++) blk[i] = 32767;
        send_block(0);
        for (int i = 0; i < 16; i++) blk[i] = -32768;
        send_block(1);
        // alternating extremes stress a-b and d
        for (int i = 0; i < 16; i++) blk[i] = (i % 3 == 0) ? 32767 : -32768;
        send_block(0);
        // row 3 repeats row 0: every column d is zero (R5 no correction)
        for (int i = 0; i < 12; i++) blk[i] = pick();
        for (int j = 0; j < 4; j++) blk[12+j] = blk[j];
        send_block(0);
        // single impulse
        for (int i = 0; i < 16; i++) blk[i] = (i == 5) ? 1000 : 0;
        send_block(2);
        stall_mode = 1'b1;
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < 16; i++) blk[i] = pick();
            if (n % 5 == 0) for (int j = 0; j < 4; j++) blk[12+j] = blk[j];
            send_block(int'($urandom % 2));
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule